// File: doc/BRIEF.md
# Fractional-Rate Core Timebase

This block produces the advance strobe for a core-local timebase and holds the timebase itself. A clock source is chosen between two tick-enable inputs: a crystal-derived tick and a core-clock tick. Every selected tick adds a programmable rate word to a phase accumulator. Each time the accumulated phase passes a whole unit of 2^(W-1), where W is the bus width, one output tick is issued. The output rate is therefore the input rate times the rate word divided by 2^(W-1). With a 32-bit bus, the value 0x80000000 gives exactly one output tick per input tick.

Every output tick advances a free-running counter of twice the bus width, by one or by two, as the step bit in the control register selects. Software reads the counter in two halves. Reading the low half captures the high half in the same cycle, so a following read of the high half returns a value that matches the low half already read. The rate word resets to zero, so nothing counts until software programs it.

Top module: `lcl_timebase`

## Requirements
- R1: After reset, the control register, the rate word, the counter and the captured high half all read as zero.
- R2: While the rate word is zero, the counter does not change, whatever ticks arrive.
- R3: With a rate word of 2^(W-1), each selected input tick advances the counter by exactly one step.
- R4: After a run of selected ticks under a fixed rate word P, the total number of output ticks equals floor((R0 + N*P) / 2^(W-1)), where N is the number of ticks and R0 is the accumulator remainder held before the run.
- R5: Control bit 8 selects the source: 0 selects xtal_tick and 1 selects core_tick. A tick on the input that is not selected has no effect on the counter.
- R6: Control bit 9 selects the step: 0 adds 1 per output tick and 1 adds 2 per output tick.
- R7: A rate word above 2^(W-1) can produce two output ticks from one input tick, and each of them advances the counter.
- R8: A read of the low half (word address 2) captures the counter's high half in the same cycle. A read of the high half (word address 3) returns that captured value, even if the counter has moved on since.
- R9: Writes to the counter addresses (2 and 3) are ignored. Control bits other than 8 and 9 are not stored and read as zero. The rate word is at word address 1 and the control register is at word address 0.
- R10: A new rate word applies from the next input tick onward. A tick in the same cycle as the write uses the old word. The accumulator remainder is kept across the change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| xtal_tick | input | 1 | Crystal-derived tick enable |
| core_tick | input | 1 | Core-clock tick enable |
| bus_we | input | 1 | Register write strobe |
| bus_re | input | 1 | Register read strobe |
| bus_addr | input | 2 | Word address |
| bus_wdata | input | BUS_W | Write data |
| bus_rdata | output | BUS_W | Read data, combinational, zero when bus_re is low |

## Verification
The bench builds the block with BUS_W set to 16. This makes the counter 32 bits wide and the 1:1 rate word 0x8000. At that width a continuous run at the highest rate, with the step set to two, carries the low half into the high half within about sixteen thousand cycles. The latch behaviour of split reads across a carry into the high half is therefore exercised, along with double carries from rate words near 0xFFFF. The same width keeps the accumulator remainder small enough that the fractional-rate sequences are easy to trace.

// File: rtl/lcl_timebase_pkg.sv
// Shared register map constants for the fractional-rate timebase.
// Assumes a word-addressed register bus with four locations.
package lcl_timebase_pkg;
    typedef enum logic [1:0] {
        RA_CTRL   = 2'd0,
        RA_RATE   = 2'd1,
        RA_CNT_LO = 2'd2,
        RA_CNT_HI = 2'd3
    } reg_addr_e;

    localparam int CTRL_SRC_BIT  = 8;
    localparam int CTRL_STEP_BIT = 9;
endpackage

// File: rtl/tmb_src_mux.sv
// Source selection: forwards the crystal tick or the core tick.
// Assumes both inputs are single-cycle enables in the clk domain.
module tmb_src_mux (
    input  logic xtal_tick,
    input  logic core_tick,
    input  logic sel_core,
    output logic tick
);
    // Pick the tick input named by the control bit.
    always_comb begin
        tick = sel_core ? core_tick : xtal_tick;
    end
endmodule

// File: rtl/tmb_frac_acc.sv
// Phase accumulator: adds the rate word on every tick and reports how many
// whole units of 2^(ACC_W-1) were crossed (0, 1 or 2).
// Assumes the rate word is ACC_W bits wide, so no more than two crossings per tick.
module tmb_frac_acc #(
    parameter int ACC_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic [ACC_W-1:0] rate,
    output logic [1:0]       carries
);
    localparam int FRAC_W = ACC_W - 1;

    logic [FRAC_W-1:0] frac_q;
    logic [ACC_W:0]    sum;

    // Form the next phase and the carry count from it.
    always_comb begin
        sum     = {2'b00, frac_q} + {1'b0, rate};
        carries = tick ? sum[ACC_W:FRAC_W] : 2'd0;
    end

    // Keep the fractional remainder across ticks.
    always_ff @(posedge clk) begin
        if (!rst_n)
            frac_q <= '0;
        else if (tick)
            frac_q <= sum[FRAC_W-1:0];
    end
endmodule

// File: rtl/tmb_counter.sv
// Free-running timebase counter, advanced by carries times the step (1 or 2).
// Assumes that a carry count is at most 2.
module tmb_counter #(
    parameter int CNT_W = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       carries,
    input  logic             step2,
    output logic [CNT_W-1:0] cnt
);
    logic [2:0] inc;

    // Scale the carry count by the selected step.
    always_comb begin
        inc = step2 ? {carries, 1'b0} : {1'b0, carries};
    end

    // Advance the counter, wrapping at its full width.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else
            cnt <= cnt + CNT_W'(inc);
    end
endmodule

// File: rtl/tmb_regs.sv
// Register file: control and rate word, plus a split counter read that
// captures the high half whenever the low half is read.
// Assumes that BUS_W is at least 10, so that both control bits fit.
module tmb_regs
    import lcl_timebase_pkg::*;
#(
    parameter int BUS_W = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bus_we,
    input  logic               bus_re,
    input  logic [1:0]         bus_addr,
    input  logic [BUS_W-1:0]   bus_wdata,
    input  logic [2*BUS_W-1:0] cnt,
    output logic               sel_core,
    output logic               step2,
    output logic [BUS_W-1:0]   rate,
    output logic [BUS_W-1:0]   hi_latch,
    output logic [BUS_W-1:0]   bus_rdata
);
    reg_addr_e addr;

    // Give the raw address its register name.
    always_comb begin
        addr = reg_addr_e'(bus_addr);
    end

    // Store the control bits and the rate word; other addresses are ignored.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_core <= 1'b0;
            step2    <= 1'b0;
            rate     <= '0;
        end else if (bus_we) begin
            if (addr == RA_CTRL) begin
                sel_core <= bus_wdata[CTRL_SRC_BIT];
                step2    <= bus_wdata[CTRL_STEP_BIT];
            end else if (addr == RA_RATE) begin
                rate <= bus_wdata;
            end
        end
    end

    // Capture the high half when the low half is read.
    always_ff @(posedge clk) begin
        if (!rst_n)
            hi_latch <= '0;
        else if (bus_re && addr == RA_CNT_LO)
            hi_latch <= cnt[2*BUS_W-1:BUS_W];
    end

    // Drive read data for the addressed location.
    always_comb begin
        bus_rdata = '0;
        if (bus_re) begin
            case (addr)
                RA_CTRL: begin
                    bus_rdata[CTRL_SRC_BIT]  = sel_core;
                    bus_rdata[CTRL_STEP_BIT] = step2;
                end
                RA_RATE:   bus_rdata = rate;
                RA_CNT_LO: bus_rdata = cnt[BUS_W-1:0];
                RA_CNT_HI: bus_rdata = hi_latch;
                default:   bus_rdata = '0;
            endcase
        end
    end
endmodule

// File: rtl/lcl_timebase.sv
// Top of the fractional-rate timebase: source mux, phase accumulator,
// counter and register file.
// Assumes that tick inputs are enables in the clk domain; the counter is 2*BUS_W wide.
module lcl_timebase #(
    parameter int BUS_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             xtal_tick,
    input  logic             core_tick,
    input  logic             bus_we,
    input  logic             bus_re,
    input  logic [1:0]       bus_addr,
    input  logic [BUS_W-1:0] bus_wdata,
    output logic [BUS_W-1:0] bus_rdata
);
    localparam int CNT_W = 2 * BUS_W;

    logic             sel_core;
    logic             step2;
    logic [BUS_W-1:0] rate;
    logic [BUS_W-1:0] hi_latch;
    logic             tick;
    logic [1:0]       carries;
    logic [CNT_W-1:0] cnt;

    tmb_src_mux u_src (
        .xtal_tick (xtal_tick),
        .core_tick (core_tick),
        .sel_core  (sel_core),
        .tick      (tick)
    );

    tmb_frac_acc #(.ACC_W(BUS_W)) u_acc (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (tick),
        .rate    (rate),
        .carries (carries)
    );

    tmb_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .carries (carries),
        .step2   (step2),
        .cnt     (cnt)
    );

    tmb_regs #(.BUS_W(BUS_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_we    (bus_we),
        .bus_re    (bus_re),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .cnt       (cnt),
        .sel_core  (sel_core),
        .step2     (step2),
        .rate      (rate),
        .hi_latch  (hi_latch),
        .bus_rdata (bus_rdata)
    );
endmodule

// File: rtl/lcl_timebase_chk.sv
// Property checker for the timebase, bound into every instance of the top.
module lcl_timebase_chk #(
    parameter int BUS_W = 32
) (
    input logic               clk,
    input logic               rst_n,
    input logic               xtal_tick,
    input logic               core_tick,
    input logic               bus_re,
    input logic [1:0]         bus_addr,
    input logic [BUS_W-1:0]   rate,
    input logic               step2,
    input logic [BUS_W-1:0]   hi_latch,
    input logic [2*BUS_W-1:0] cnt
);
    localparam int CNT_W = 2 * BUS_W;

    logic [CNT_W-1:0] cnt_prev;
    logic [CNT_W-1:0] delta;

    always_ff @(posedge clk) begin
        cnt_prev <= cnt;
    end

    always_comb begin
        delta = cnt - cnt_prev;
    end

    // R1
    reset_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> (cnt == '0 && hi_latch == '0));

    // R2
    zero_rate_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rate) == '0) |-> $stable(cnt));

    // R5
    no_tick_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(xtal_tick) && !$past(core_tick)) |-> $stable(cnt));

    // R6
    unit_step_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(step2) && !$past(!rst_n)) |-> (delta <= CNT_W'(2)));

    // R7
    max_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(!rst_n) |-> (delta <= CNT_W'(4)));

    // R8
    hi_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_re && bus_addr == 2'd2) |=> (hi_latch == $past(cnt[CNT_W-1:BUS_W])));
endmodule

bind lcl_timebase lcl_timebase_chk #(.BUS_W(BUS_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .xtal_tick (xtal_tick),
    .core_tick (core_tick),
    .bus_re    (bus_re),
    .bus_addr  (bus_addr),
    .rate      (rate),
    .step2     (step2),
    .hi_latch  (hi_latch),
    .cnt       (cnt)
);

// File: tb/lcl_timebase_test.sv
module lcl_timebase_test;
    localparam int W    = 16;
    localparam int FW   = W - 1;
    localparam int UNIT = 1 << FW;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         xtal_tick = 1'b0;
    logic         core_tick = 1'b0;
    logic         bus_we = 1'b0;
    logic         bus_re = 1'b0;
    logic [1:0]   bus_addr = 2'd0;
    logic [W-1:0] bus_wdata = '0;
    logic [W-1:0] bus_rdata;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    lcl_timebase #(.BUS_W(W)) uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .xtal_tick (xtal_tick),
        .core_tick (core_tick),
        .bus_we    (bus_we),
        .bus_re    (bus_re),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata)
    );

    // Reference model built from the requirements
    longint       m_frac;
    longint       m_rate;
    bit           m_core;
    bit           m_step2;
    logic [2*W-1:0] m_cnt;

    always @(posedge clk) begin
        longint s;
        bit t;
        if (!rst_n) begin
            m_frac = 0; m_rate = 0; m_core = 0; m_step2 = 0; m_cnt = '0;
        end else begin
            t = m_core ? core_tick : xtal_tick;
            if (t) begin
                s = m_frac + m_rate;
                m_frac = s % UNIT;
                m_cnt = m_cnt + (2*W)'((s / UNIT) * (m_step2 ? 2 : 1));
            end
            if (bus_we && bus_addr == 2'd0) begin
                m_core = bus_wdata[8]; m_step2 = bus_wdata[9];
            end else if (bus_we && bus_addr == 2'd1) begin
                m_rate = longint'(bus_wdata);
            end
        end
    end

    function automatic logic [W-1:0] ctrl_view(input logic [W-1:0] w);
        return w & W'(16'h0300);
    endfunction

    task automatic check(input string req, input logic [W-1:0] got, input logic [W-1:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic drive(input bit xt, input bit ct, input bit we, input bit re,
                         input logic [1:0] a, input logic [W-1:0] d);
        @(negedge clk);
        xtal_tick = xt; core_tick = ct; bus_we = we; bus_re = re;
        bus_addr = a; bus_wdata = d;
    endtask

    task automatic wr(input logic [1:0] a, input logic [W-1:0] d);
        drive(0, 0, 1, 0, a, d);
        drive(0, 0, 0, 0, 2'd0, '0);
    endtask

    task automatic ticks(input int n, input bit xt, input bit ct);
        for (int i = 0; i < n; i++) drive(xt, ct, 0, 0, 2'd0, '0);
        drive(0, 0, 0, 0, 2'd0, '0);
    endtask

    // Split read of the counter; ticks may run during the reads
    task automatic read_cnt(input string req, input bit xt, input bit ct);
        logic [W-1:0] exp_hi;
        drive(xt, ct, 0, 1, 2'd2, '0);
        #1;
        check(req, bus_rdata, m_cnt[W-1:0]);
        exp_hi = m_cnt[2*W-1:W];
        drive(xt, ct, 0, 1, 2'd3, '0);
        #1;
        check(req, bus_rdata, exp_hi);
        drive(0, 0, 0, 0, 2'd0, '0);
    endtask

    task automatic read_reg(input string req, input logic [1:0] a, input logic [W-1:0] exp);
        drive(0, 0, 0, 1, a, '0);
        #1;
        check(req, bus_rdata, exp);
        drive(0, 0, 0, 0, 2'd0, '0);
    endtask

    initial begin
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        read_reg("R1", 2'd0, '0);
        read_reg("R1", 2'd1, '0);
        read_reg("R1", 2'd3, '0);
        read_reg("R1", 2'd2, '0);

        // R2 zero rate word: ticks do nothing
        ticks(20, 1, 1);
        read_cnt("R2", 0, 0);
        check("R2", m_cnt[W-1:0], '0);

        // R3 1:1 rate on the crystal tick
        wr(2'd1, W'(UNIT));
        read_reg("R10", 2'd1, W'(UNIT));
        ticks(10, 1, 0);
        read_cnt("R3", 0, 0);
        check("R3", m_cnt[W-1:0], W'(10));

        // R5 core tick ignored while crystal is selected
        ticks(8, 0, 1);
        read_cnt("R5", 0, 0);
        check("R5", m_cnt[W-1:0], W'(10));
        wr(2'd0, W'(16'h0100));
        ticks(5, 0, 1);
        ticks(5, 1, 0);
        read_cnt("R5", 0, 0);
        check("R5", m_cnt[W-1:0], W'(15));

        // R6 step of two
        wr(2'd0, W'(16'h0300));
        ticks(4, 0, 1);
        read_cnt("R6", 0, 0);
        check("R6", m_cnt[W-1:0], W'(23));

        // R9 control reserved bits, counter writes ignored
        wr(2'd0, W'(16'hFFFF));
        read_reg("R9", 2'd0, ctrl_view(W'(16'hFFFF)));
        wr(2'd2, W'(16'h1234));
        wr(2'd3, W'(16'h5678));
        read_cnt("R9", 0, 0);
        wr(2'd0, W'(16'h0000));

        // R4 R10 half rate: remainder carries across ticks and a rate change
        wr(2'd1, W'(UNIT / 2));
        ticks(3, 1, 0);
        read_cnt("R4", 0, 0);
        drive(1, 0, 1, 0, 2'd1, W'(UNIT / 4));
        ticks(2, 1, 0);
        read_cnt("R10", 0, 0);

        // R7 rate near two units, double carries
        wr(2'd1, W'(16'hFFFF));
        ticks(6, 1, 0);
        read_cnt("R7", 0, 0);

        // R8 counter runs during the split read
        read_cnt("R8", 1, 0);
        read_cnt("R8", 1, 0);

        // R4 random mix of rates, sources, steps and ticks
        for (int i = 0; i < 3000; i++) begin
            int r;
            r = int'($urandom % 100);
            if (r < 3)
                wr(2'd0, W'($urandom) & W'(16'h0300));
            else if (r < 6)
                wr(2'd1, W'($urandom));
            else if (r < 10)
                read_cnt("R4", bit'($urandom), bit'($urandom));
            else
                drive(bit'($urandom), bit'($urandom), 0, 0, 2'd0, '0);
        end

        // R8 carry into the high half at the highest rate
        wr(2'd1, W'(16'hFFFF));
        wr(2'd0, W'(16'h0300));
        for (int k = 0; k < 40; k++) begin
            ticks(500, 0, 1);
            read_cnt("R8", 0, 1);
        end
        check("R8", W'(m_cnt[2*W-1:W] != '0), W'(1));

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        #(4 * 150000);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule